// File: doc/BRIEF.md
# Affine Background Address Generator

This block drives a rotate-and-scale background layer. For every pixel of a 256-pixel line it tracks where that pixel lands on a 1024×1024-pixel map after a 2×2 signed fixed-point matrix is applied about a programmable center point. It turns that map position into a tilemap word address and a pixel position inside an 8×8 tile. A two-bit edge code tells the pixel fetch stage what to do when the position falls off the map.

Software programs the matrix, the center, the scroll offsets and a settings byte through a byte-wide write port. At the start of each line the block computes the line's first map coordinate with full multiplies. After that, each pixel-advance strobe moves the coordinate by one matrix column with a single add per axis. Memory fetch, colour lookup and layer mixing sit downstream.

Top module: `affine_bg_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all registers and the byte latch clear. After reset, `map_addr`, `fine_x`, `fine_y` and `edge_code` read zero until the first line start.
- R2: The `reg_sel` codes are 0 settings, 1 matrix A, 2 matrix B, 3 matrix C, 4 matrix D, 5 center X, 6 center Y, 7 horizontal scroll and 8 vertical scroll. Codes 9 to 15 are ignored. A word write loads `{reg_data, latch}` and then copies `reg_data` into the one latch shared by all word registers, so each register is written low byte first and then high byte. Matrix entries keep 16 bits (signed 8.8). Center and scroll keep the low 13 bits, with bit 12 as the sign. A settings write does not touch the latch.
- R3: On `line_start`, the X coordinate becomes A·(sx−cx) + B·(sy−cy) + cx·256 and Y becomes C·(sx−cx) + D·(sy−cy) + cy·256. Here sx is the first screen column plus the horizontal scroll, and sy is the screen line plus the vertical scroll. The integer map position is the coordinate shifted right arithmetically by 8.
- R4: Each `pix_step` without `line_start` adds A to X and C to Y. Without either strobe, the address and fine outputs hold their values.
- R5: When settings bit 0 is set (horizontal flip), the first screen column is 255, and each step subtracts A from X and C from Y.
- R6: When settings bit 1 is set (vertical flip), the screen line used is 255 − `line_num`.
- R7: `map_addr` is {Y[9:3], X[9:3]} of the wrapped integer map position, with the row in bits 13:7. `fine_x` is X[2:0] and `fine_y` is Y[2:0].
- R8: When settings bits 3:2 are 0 or 1 (wrap), positions outside 0..1023 wrap modulo 1024 and `edge_code` stays 0.
- R9: When settings bits 3:2 are 2, a position outside the map on either axis gives `edge_code` 1 (transparent). The value 3 never appears on `edge_code`.
- R10: When settings bits 3:2 are 3, a position outside the map gives `edge_code` 2 (use tile 0), and the fine outputs still come from the wrapped position.
- R11: When `line_start` and `pix_step` are high together, the line start wins and the coordinate is the line's first pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select code |
| reg_data | input | 8 | Write data byte |
| line_start | input | 1 | Start-of-line strobe |
| line_num | input | 8 | Screen line number, sampled with `line_start` |
| pix_step | input | 1 | Advance to the next screen pixel |
| map_addr | output | 14 | Tilemap word address |
| fine_x | output | 3 | Column inside the tile |
| fine_y | output | 3 | Row inside the tile |
| edge_code | output | 2 | 0 normal, 1 transparent, 2 use tile 0 |

## Verification
The checker watches four things on every cycle: that the outputs are cleared after reset, that the address holds while no strobe is present, that each edge code appears only under its own settings mode, and that wrap mode never raises an edge code. The arithmetic itself can only be shown by the bench's scenarios. Those cover the start-coordinate formula, stepping in both directions, flips, fractional scaling, negative centers and scrolls, the shared byte latch, and line-start priority. For each one the bench compares the outputs against a direct per-pixel evaluation of the matrix.

// File: rtl/affine_pkg.sv
package affine_pkg;

    localparam int BYTE_W      = 8;
    localparam int SEL_W       = 4;
    localparam int MAT_W       = 16;
    localparam int POS_W       = 13;
    localparam int FRAC_W      = 8;
    localparam int ACC_W       = 32;
    localparam int MAP_PX_W    = 10;
    localparam int FINE_W      = 3;
    localparam int TILE_IDX_W  = MAP_PX_W - FINE_W;
    localparam int ADDR_W      = 2 * TILE_IDX_W;
    localparam int AXES        = 2;
    localparam int AX_X        = 0;
    localparam int AX_Y        = 1;
    localparam int SCREEN_LAST = 255;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 4'd0,
        SEL_MA   = 4'd1,
        SEL_MB   = 4'd2,
        SEL_MC   = 4'd3,
        SEL_MD   = 4'd4,
        SEL_CX   = 4'd5,
        SEL_CY   = 4'd6,
        SEL_HS   = 4'd7,
        SEL_VS   = 4'd8
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_WRAP0 = 2'd0,
        MODE_WRAP1 = 2'd1,
        MODE_CLEAR = 2'd2,
        MODE_TILE0 = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        EDGE_INSIDE = 2'd0,
        EDGE_CLEAR  = 2'd1,
        EDGE_TILE0  = 2'd2
    } edge_code_e;

    // settings byte bits [3:0]: {mode[1:0], vflip, hflip}
    typedef struct packed {
        edge_mode_e mode;
        logic       vflip;
        logic       hflip;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [MAT_W-1:0]  ma;
        logic [MAT_W-1:0]  mb;
        logic [MAT_W-1:0]  mc;
        logic [MAT_W-1:0]  md;
        logic [POS_W-1:0]  cx;
        logic [POS_W-1:0]  cy;
        logic [POS_W-1:0]  hs;
        logic [POS_W-1:0]  vs;
    } affine_cfg_t;

    typedef logic [AXES-1:0][ACC_W-1:0] coord_pair_t;

    function automatic logic [ACC_W-1:0] ext_mat(input logic [MAT_W-1:0] v);
        return {{(ACC_W-MAT_W){v[MAT_W-1]}}, v};
    endfunction

    function automatic logic [ACC_W-1:0] ext_pos(input logic [POS_W-1:0] v);
        return {{(ACC_W-POS_W){v[POS_W-1]}}, v};
    endfunction

    function automatic logic [ACC_W-1:0] zext_scr(input logic [BYTE_W-1:0] v);
        return {{(ACC_W-BYTE_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/affine_regs.sv
module affine_regs
    import affine_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output affine_cfg_t       cfg
);

    logic [BYTE_W-1:0]   latch_q;
    logic [2*BYTE_W-1:0] word;

    assign word = {wr_data, latch_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            latch_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_CTRL: cfg.ctrl <= ctrl_t'(wr_data[3:0]);
                SEL_MA: begin cfg.ma <= word[MAT_W-1:0]; latch_q <= wr_data; end
                SEL_MB: begin cfg.mb <= word[MAT_W-1:0]; latch_q <= wr_data; end
                SEL_MC: begin cfg.mc <= word[MAT_W-1:0]; latch_q <= wr_data; end
                SEL_MD: begin cfg.md <= word[MAT_W-1:0]; latch_q <= wr_data; end
                SEL_CX: begin cfg.cx <= word[POS_W-1:0]; latch_q <= wr_data; end
                SEL_CY: begin cfg.cy <= word[POS_W-1:0]; latch_q <= wr_data; end
                SEL_HS: begin cfg.hs <= word[POS_W-1:0]; latch_q <= wr_data; end
                SEL_VS: begin cfg.vs <= word[POS_W-1:0]; latch_q <= wr_data; end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/affine_line_setup.sv
module affine_line_setup
    import affine_pkg::*;
(
    input  affine_cfg_t       cfg,
    input  logic [BYTE_W-1:0] line_num,
    output coord_pair_t       start_pt,
    output coord_pair_t       step_pt
);

    logic [BYTE_W-1:0] scr_x0;
    logic [BYTE_W-1:0] scr_y0;
    logic [ACC_W-1:0]  dx;
    logic [ACC_W-1:0]  dy;
    logic [ACC_W-1:0]  ma_w, mb_w, mc_w, md_w;

    assign scr_x0 = cfg.ctrl.hflip ? BYTE_W'(SCREEN_LAST) : '0;
    assign scr_y0 = cfg.ctrl.vflip ? (BYTE_W'(SCREEN_LAST) - line_num) : line_num;

    assign ma_w = ext_mat(cfg.ma);
    assign mb_w = ext_mat(cfg.mb);
    assign mc_w = ext_mat(cfg.mc);
    assign md_w = ext_mat(cfg.md);

    // offsets from the center, two's complement at full width
    assign dx = zext_scr(scr_x0) + ext_pos(cfg.hs) - ext_pos(cfg.cx);
    assign dy = zext_scr(scr_y0) + ext_pos(cfg.vs) - ext_pos(cfg.cy);

    assign start_pt[AX_X] = ma_w * dx + mb_w * dy + (ext_pos(cfg.cx) << FRAC_W);
    assign start_pt[AX_Y] = mc_w * dx + md_w * dy + (ext_pos(cfg.cy) << FRAC_W);

    // one screen column moves the map point by the first matrix column
    assign step_pt[AX_X] = cfg.ctrl.hflip ? (ACC_W'(0) - ma_w) : ma_w;
    assign step_pt[AX_Y] = cfg.ctrl.hflip ? (ACC_W'(0) - mc_w) : mc_w;

endmodule

// File: rtl/affine_stepper.sv
module affine_stepper
    import affine_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        line_start,
    input  logic        pix_step,
    input  coord_pair_t start_pt,
    input  coord_pair_t step_pt,
    output coord_pair_t acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else begin
            for (int ax = 0; ax < AXES; ax++) begin
                if (line_start) begin
                    acc[ax] <= start_pt[ax];
                end else if (pix_step) begin
                    acc[ax] <= acc[ax] + step_pt[ax];
                end
            end
        end
    end

endmodule

// File: rtl/affine_addr.sv
module affine_addr
    import affine_pkg::*;
(
    input  coord_pair_t            acc,
    input  edge_mode_e             mode,
    output logic [ADDR_W-1:0]      map_addr,
    output logic [FINE_W-1:0]      fine_x,
    output logic [FINE_W-1:0]      fine_y,
    output edge_code_e             edge_code
);

    logic [AXES-1:0]                 outside;
    logic [AXES-1:0][TILE_IDX_W-1:0] tile_idx;
    logic [AXES-1:0][FINE_W-1:0]     fine;

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        assign outside[g]  = |acc[g][ACC_W-1:FRAC_W+MAP_PX_W];
        assign tile_idx[g] = acc[g][FRAC_W+MAP_PX_W-1:FRAC_W+FINE_W];
        assign fine[g]     = acc[g][FRAC_W+FINE_W-1:FRAC_W];
    end

    assign map_addr = {tile_idx[AX_Y], tile_idx[AX_X]};
    assign fine_x   = fine[AX_X];
    assign fine_y   = fine[AX_Y];

    always_comb begin
        edge_code = EDGE_INSIDE;
        if (|outside) begin
            case (mode)
                MODE_CLEAR: edge_code = EDGE_CLEAR;
                MODE_TILE0: edge_code = EDGE_TILE0;
                default:    edge_code = EDGE_INSIDE;
            endcase
        end
    end

endmodule

// File: rtl/affine_bg_addr_gen.sv
module affine_bg_addr_gen
    import affine_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_data,
    input  logic              line_start,
    input  logic [BYTE_W-1:0] line_num,
    input  logic              pix_step,
    output logic [ADDR_W-1:0] map_addr,
    output logic [FINE_W-1:0] fine_x,
    output logic [FINE_W-1:0] fine_y,
    output logic [1:0]        edge_code
);

    affine_cfg_t cfg;
    coord_pair_t start_pt;
    coord_pair_t step_pt;
    coord_pair_t acc;
    edge_code_e  edge_e;
    logic [1:0]  cfg_mode;

    assign cfg_mode  = cfg.ctrl.mode;
    assign edge_code = edge_e;

    affine_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_data (reg_data),
        .cfg     (cfg)
    );

    affine_line_setup u_setup (
        .cfg      (cfg),
        .line_num (line_num),
        .start_pt (start_pt),
        .step_pt  (step_pt)
    );

    affine_stepper u_step (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .pix_step   (pix_step),
        .start_pt   (start_pt),
        .step_pt    (step_pt),
        .acc        (acc)
    );

    affine_addr u_addr (
        .acc       (acc),
        .mode      (cfg.ctrl.mode),
        .map_addr  (map_addr),
        .fine_x    (fine_x),
        .fine_y    (fine_y),
        .edge_code (edge_e)
    );

endmodule

// File: rtl/affine_bg_addr_gen_chk.sv
module affine_bg_addr_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        line_start,
    input logic        pix_step,
    input logic [1:0]  cfg_mode,
    input logic [13:0] map_addr,
    input logic [2:0]  fine_x,
    input logic [2:0]  fine_y,
    input logic [1:0]  edge_code
);

    logic was_rst = 1'b0;

    always_ff @(posedge clk) was_rst <= rst;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        was_rst |-> (map_addr == '0 && fine_x == '0 && fine_y == '0 && edge_code == '0)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!line_start && !pix_step) |=> ($stable(map_addr) && $stable(fine_x) && $stable(fine_y))); // R4

    AST_WRAP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode < 2'd2) |-> (edge_code == 2'd0)); // R8

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        edge_code != 2'd3); // R9

    AST_CLEAR_MODE: assert property (@(posedge clk) disable iff (rst)
        (edge_code == 2'd1) |-> (cfg_mode == 2'd2)); // R9

    AST_TILE0_MODE: assert property (@(posedge clk) disable iff (rst)
        (edge_code == 2'd2) |-> (cfg_mode == 2'd3)); // R10

endmodule

bind affine_bg_addr_gen affine_bg_addr_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .pix_step   (pix_step),
    .cfg_mode   (cfg_mode),
    .map_addr   (map_addr),
    .fine_x     (fine_x),
    .fine_y     (fine_y),
    .edge_code  (edge_code)
);

// File: tb/affine_bg_addr_gen_bench.sv
module affine_bg_addr_gen_bench;
    import affine_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [7:0]  reg_data = '0;
    logic        line_start = 1'b0;
    logic [7:0]  line_num = '0;
    logic        pix_step = 1'b0;
    logic [13:0] map_addr;
    logic [2:0]  fine_x;
    logic [2:0]  fine_y;
    logic [1:0]  edge_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    affine_bg_addr_gen u_affine_bg_addr_gen (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_data   (reg_data),
        .line_start (line_start),
        .line_num   (line_num),
        .pix_step   (pix_step),
        .map_addr   (map_addr),
        .fine_x     (fine_x),
        .fine_y     (fine_y),
        .edge_code  (edge_code)
    );

    typedef struct packed {
        int ctrl; int ma; int mb; int mc; int md;
        int cx; int cy; int hs; int vs; int ln; int n;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{0,  256,    0,   0, 256,   0,   0,   0,   0,  10,  37},
        '{0,  512,    0,   0, 512,   0,   0, 100,  20,  50, 200},
        '{0,  224, -128, 128, 224, -50, 112,   5,  -7, 100, 255},
        '{3,  256,    0,   0, 256,   0,   0,   0,   0,   3,  10},
        '{8, -256,    0,   0, 256,   0,   0,   0,   0,   5,  20},
        '{12, 768,    0,   0, 256,   0,   0, 200,   0,   0, 255},
        '{0,  256,    0,   0, 256,   0,   0,   0, -40,  10,   4},
        '{0,  384,    0,   0, 256,   0,   0,   0,   0,   7,   3},
        '{1,  256,    0,  64, 256,   0,   0,   0,   0,  20, 100}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R3 identity";
            1: return "R4 scaled stepping";
            2: return "R3 rotation negative center";
            3: return "R5 R6 both flips";
            4: return "R9 transparent";
            5: return "R10 tile zero";
            6: return "R8 wrap negative";
            7: return "R3 fractional";
            default: return "R5 hflip with C";
        endcase
    endfunction

    // direct per-pixel evaluation: {addr14, fx3, fy3, code2}
    function automatic logic [21:0] ref_px(input int ctrl, input int ma, input int mb,
                                           input int mc, input int md, input int cx,
                                           input int cy, input int hs, input int vs,
                                           input int ln, input int n);
        int sx, sy, xv, yv, xi, yi, mode, code;
        logic off;
        sx = (((ctrl & 1) != 0) ? 255 - n : n) + hs;
        sy = (((ctrl & 2) != 0) ? 255 - ln : ln) + vs;
        xv = ma * (sx - cx) + mb * (sy - cy) + cx * 256;
        yv = mc * (sx - cx) + md * (sy - cy) + cy * 256;
        xi = xv >>> 8;
        yi = yv >>> 8;
        off = (xi < 0) || (xi > 1023) || (yi < 0) || (yi > 1023);
        mode = (ctrl >> 2) & 3;
        code = !off ? 0 : (mode == 2) ? 1 : (mode == 3) ? 2 : 0;
        xi = xi & 1023;
        yi = yi & 1023;
        return {14'(((yi >> 3) << 7) | (xi >> 3)), 3'(xi & 7), 3'(yi & 7), 2'(code)};
    endfunction

    task automatic check_field(input string what, input string tag,
                               input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [21:0] exp);
        check_field("R7 map_addr", tag, 32'(map_addr), 32'(exp[21:8]));
        check_field("R7 fine_x", tag, 32'(fine_x), 32'(exp[7:5]));
        check_field("R7 fine_y", tag, 32'(fine_y), 32'(exp[4:2]));
        check_field("edge_code", tag, 32'(edge_code), 32'(exp[1:0]));
    endtask

    task automatic wr_byte(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_data = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic load_word(input logic [3:0] sel, input int v);
        logic [15:0] w;
        w = 16'(v);
        wr_byte(sel, w[7:0]);
        wr_byte(sel, w[15:8]);
    endtask

    task automatic load_vec(input vec_t v);
        wr_byte(SEL_CTRL, 8'(v.ctrl));
        load_word(SEL_MA, v.ma);
        load_word(SEL_MB, v.mb);
        load_word(SEL_MC, v.mc);
        load_word(SEL_MD, v.md);
        load_word(SEL_CX, v.cx);
        load_word(SEL_CY, v.cy);
        load_word(SEL_HS, v.hs);
        load_word(SEL_VS, v.vs);
    endtask

    task automatic new_line(input int ln);
        @(negedge clk);
        line_start = 1'b1; line_num = 8'(ln);
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic do_steps(input int n);
        if (n > 0) begin
            pix_step = 1'b1;
            repeat (n) @(negedge clk);
            pix_step = 1'b0;
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired got 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs clear after reset
        check_all("R1 reset", 22'd0);
        repeat (2) @(negedge clk);
        check_all("R1 reset hold", 22'd0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            load_vec(v);
            new_line(v.ln);
            do_steps(v.n);
            check_all(vec_tag(i), ref_px(v.ctrl, v.ma, v.mb, v.mc, v.md, v.cx, v.cy,
                                         v.hs, v.vs, v.ln, v.n));
        end

        // R2: 13-bit truncation and shared latch across registers
        v = VECS[0];
        load_vec(v);
        wr_byte(SEL_HS, 8'h05);
        wr_byte(SEL_HS, 8'hE0);   // hs = 0xE005 -> 13 bits = 5
        wr_byte(SEL_VS, 8'h00);   // vs = {0x00, latch 0xE0} = 224
        new_line(0);
        check_all("R2 shared latch", ref_px(0, 256, 0, 0, 256, 0, 0, 5, 224, 0, 0));

        // R2: unused select code has no effect
        wr_byte(4'd12, 8'hFF);
        new_line(0);
        check_all("R2 unused select", ref_px(0, 256, 0, 0, 256, 0, 0, 5, 224, 0, 0));

        // R11: line start beats a simultaneous pixel step
        do_steps(9);
        @(negedge clk);
        line_start = 1'b1; pix_step = 1'b1; line_num = 8'd30;
        @(negedge clk);
        line_start = 1'b0; pix_step = 1'b0;
        check_all("R11 start priority", ref_px(0, 256, 0, 0, 256, 0, 0, 5, 224, 30, 0));

        // R4: single step, then idle hold
        do_steps(1);
        check_all("R4 single step", ref_px(0, 256, 0, 0, 256, 0, 0, 5, 224, 30, 1));
        repeat (5) @(negedge clk);
        check_all("R4 idle hold", ref_px(0, 256, 0, 0, 256, 0, 0, 5, 224, 30, 1));

        // R9: transparent mode with Y leaving the map at the far edge
        wr_byte(SEL_CTRL, 8'h08);
        load_word(SEL_VS, 1000);
        new_line(40);
        do_steps(2);
        check_all("R9 far edge", ref_px(8, 256, 0, 0, 256, 0, 0, 5, 1000, 40, 2));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule